// File: doc/BRIEF.md
# Memory range type resolver

This block maps a physical address to a caching type. It holds eight variable-range entries. Each entry is a pair: a base register carries a type code and a page-frame number, and a mask register carries a page-frame mask and a valid flag. It also holds a global control register, which gives a fallback type and an enable, and a read-only capability register that reports how many entries exist.

Software reaches the registers through a simple indexed port. The port takes a read strobe or a write strobe, a 12-bit register index and 64-bit data. Read data and an error strobe are registered and appear one cycle after the read strobe.

The lookup side takes a 52-bit address with a strobe. One clock later it presents a 3-bit type and a hit flag, and it holds them until the next strobe. An entry matches when the masked base equals the masked address page frame. This is a pure bitwise compare, so a range is only meaningful when its size is a power of two and its base is aligned to that size. When several valid entries match, a fixed priority between types picks the result.

Top module: `memtype_resolver`

## Requirements
- R1: Index 0x0FE is a read-only capability register. Bits 7:0 read as 8, the number of entries, and all other bits read as zero. Writes to it change nothing.
- R2: Entry i has its base register at index 0x200+2i and its mask register at index 0x201+2i. In the base register, bits 2:0 are the type and bits 51:12 are the page frame. In the mask register, bit 11 is the valid flag and bits 51:12 are the page-frame mask. All other bits of both registers ignore writes and read as zero.
- R3: Index 0x2FF is the control register. Bits 2:0 are the fallback type and bit 11 is the global enable. All other bits read as zero.
- R4: A valid entry matches address A when (mask AND base) equals (mask AND A[51:12]), compared over all 40 page-frame bits.
- R5: An entry whose valid flag is clear never matches, whatever its base and mask contents, including an all-zero mask.
- R6: With the enable set and no valid entry matching, the result is the fallback type and the hit flag is 0.
- R7: With the enable clear, every lookup returns type 000 (uncacheable) with the hit flag 0.
- R8: Overlap rules, when one or more valid entries match with the enable set (hit flag 1):
  - any matching type 000 gives 000;
  - a single distinct type gives that type;
  - the set {100 write-through, 110 write-back} gives 100;
  - any other mix gives 000.
- R9: A read of an index outside 0x0FE, 0x200 to 0x20F and 0x2FF returns zero and raises reg_err for exactly one cycle, together with the read data. reg_err stays low after reads of implemented indices.
- R10: After reset, all valid flags, the enable and the fallback type are zero. Every lookup therefore returns 000 with no hit.
- R11: The lookup result and hit flag appear on the clock edge that samples the strobe and hold until the next strobe. A register write in the same cycle as a strobe affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 12 | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| reg_err | output | 1 | Pulses with the read data of an unimplemented index |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 52 | Physical address to classify |
| lk_type | output | 3 | Resolved type, registered |
| lk_hit | output | 1 | Set when a valid entry matched |

## Verification
Each configuration is swept over addresses at the edges of every programmed range: one page below the base, the base itself, the last byte inside, and the first byte past the end. These probes separate a correct masked compare from an off-by-one or an unmasked one. The configurations are a set of nested and overlapping ranges of several types, the same set with an always-matching entry added, and the same set with the enable clear. Between them they exercise every overlap rule, the fallback path and the disabled path. Pseudo-random addresses fill in the space between the edges. Register read-back with all-ones data, reads of unimplemented indices, and a write that coincides with a lookup cover the register port and the timing rule.

// File: rtl/memtype_resolver.sv
module memtype_resolver #(
  parameter int NPAIR = 8,
  parameter int PA_W = 52,
  parameter int IDX_W = 12,
  parameter logic [IDX_W-1:0] PAIR_IDX = 12'h200,
  parameter logic [IDX_W-1:0] CTRL_IDX = 12'h2FF,
  parameter logic [IDX_W-1:0] CAP_IDX = 12'h0FE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  output logic             reg_err,
  input  logic             lk_valid,
  input  logic [PA_W-1:0]  lk_addr,
  output logic [2:0]       lk_type,
  output logic             lk_hit
);
  localparam int PFN_W = PA_W - 12;
  localparam int SW = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam logic [IDX_W-1:0] PAIR_END = IDX_W'(int'(PAIR_IDX) + 2 * NPAIR);

  logic [2:0]       b_type [NPAIR];
  logic [PFN_W-1:0] b_pfn  [NPAIR];
  logic [PFN_W-1:0] m_pfn  [NPAIR];
  logic [NPAIR-1:0] m_vld;
  logic [2:0]       def_type;
  logic             en;

  logic             in_pairs;
  logic [IDX_W-1:0] off;
  logic [SW-1:0]    sel;

  assign in_pairs = (reg_idx >= PAIR_IDX) && (reg_idx < PAIR_END);
  assign off = reg_idx - PAIR_IDX;
  assign sel = off[SW:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIR; i++) begin
        b_type[i] <= '0;
        b_pfn[i]  <= '0;
        m_pfn[i]  <= '0;
      end
      m_vld    <= '0;
      def_type <= '0;
      en       <= 1'b0;
    end else if (reg_wr) begin
      if (in_pairs) begin
        if (!off[0]) begin
          b_type[sel] <= reg_wdata[2:0];
          b_pfn[sel]  <= reg_wdata[PA_W-1:12];
        end else begin
          m_vld[sel] <= reg_wdata[11];
          m_pfn[sel] <= reg_wdata[PA_W-1:12];
        end
      end else if (reg_idx == CTRL_IDX) begin
        def_type <= reg_wdata[2:0];
        en       <= reg_wdata[11];
      end
    end
  end

  logic [63:0] rd_val;
  logic        rd_bad;

  always_comb begin
    rd_val = '0;
    rd_bad = 1'b0;
    if (in_pairs) begin
      if (!off[0]) begin
        rd_val[PA_W-1:12] = b_pfn[sel];
        rd_val[2:0]       = b_type[sel];
      end else begin
        rd_val[PA_W-1:12] = m_pfn[sel];
        rd_val[11]        = m_vld[sel];
      end
    end else if (reg_idx == CTRL_IDX) begin
      rd_val[2:0] = def_type;
      rd_val[11]  = en;
    end else if (reg_idx == CAP_IDX) begin
      rd_val[7:0] = 8'(NPAIR);
    end else begin
      rd_bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else if (reg_rd) begin
      reg_rdata <= rd_val;
      reg_err   <= rd_bad;
    end else begin
      reg_err <= 1'b0;
    end
  end

  logic [NPAIR-1:0] hits;
  logic [7:0]       tset;
  logic [2:0]       single;
  logic [2:0]       res_type;

  for (genvar i = 0; i < NPAIR; i++) begin : g_match
    assign hits[i] = m_vld[i] &&
                     ((m_pfn[i] & b_pfn[i]) == (m_pfn[i] & lk_addr[PA_W-1:12]));
  end

  always_comb begin
    tset = '0;
    for (int i = 0; i < NPAIR; i++)
      if (hits[i]) tset[b_type[i]] = 1'b1;
  end

  always_comb begin
    single = '0;
    for (int k = 0; k < 8; k++)
      if (tset[k]) single = 3'(k);
  end

  always_comb begin
    if (!en)                res_type = 3'd0;
    else if (hits == '0)    res_type = def_type;
    else if (tset[0])       res_type = 3'd0;
    else if ($onehot(tset)) res_type = single;
    else if (tset == 8'h50) res_type = 3'd4;
    else                    res_type = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_type <= '0;
      lk_hit  <= 1'b0;
    end else if (lk_valid) begin
      lk_type <= res_type;
      lk_hit  <= en && (hits != '0);
    end
  end

  // R7
  disabled_uc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !en |=> lk_type == 3'd0 && !lk_hit);

  // R6
  fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && en && hits == '0 |=> lk_type == $past(def_type) && !lk_hit);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(lk_type) && $stable(lk_hit));

  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> $past(reg_rd) && reg_rdata == 64'd0);

  // R1
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_idx == CAP_IDX |=> reg_rdata == 64'(NPAIR) && !reg_err);

  // R2
  rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[63:PA_W] == '0 && reg_rdata[10:8] == 3'd0);

  // R5
  invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && m_vld == '0 |=> !lk_hit);
endmodule

// File: tb/memtype_resolver_bench.sv
module memtype_resolver_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_idx = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        reg_err;
  logic        lk_valid = 1'b0;
  logic [51:0] lk_addr = '0;
  logic [2:0]  lk_type;
  logic        lk_hit;

  int n_cmp = 0, n_bad = 0;

  logic [63:0] mbase [8];
  logic [63:0] mmask [8];
  logic [63:0] mctrl;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD / 2) clk = ~clk;

  memtype_resolver u_memtype_resolver (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_type(lk_type), .lk_hit(lk_hit)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [51:0] a);
    logic [7:0] s = '0;
    logic [2:0] t = '0;
    if (!mctrl[11]) return 4'h0;
    for (int i = 0; i < 8; i++)
      if (mmask[i][11] && ((mmask[i][51:12] & mbase[i][51:12]) == (mmask[i][51:12] & a[51:12])))
        s[mbase[i][2:0]] = 1'b1;
    if (s == 0) return {1'b0, mctrl[2:0]};
    for (int k = 0; k < 8; k++) if (s[k]) t = 3'(k);
    if (s[0]) t = 3'd0;
    else if ($countones(s) == 1) t = t;
    else if (s == 8'h50) t = 3'd4;
    else t = 3'd0;
    return {1'b1, t};
  endfunction

  task automatic model_write(input logic [11:0] idx, input logic [63:0] d);
    if (idx >= 12'h200 && idx <= 12'h20F) begin
      if (!idx[0]) mbase[idx[3:1]] = d & 64'h000F_FFFF_FFFF_F007;
      else         mmask[idx[3:1]] = d & 64'h000F_FFFF_FFFF_F800;
    end else if (idx == 12'h2FF) mctrl = d & 64'h807;
  endtask

  task automatic wr(input logic [11:0] idx, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    model_write(idx, d);
  endtask

  task automatic rd(input logic [11:0] idx, input logic [63:0] exp, input logic exp_err, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_idx = idx;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, reg_rdata, exp);
    check({tag, " err"}, 64'(reg_err), 64'(exp_err));
  endtask

  task automatic look(input logic [51:0] a, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check(tag, {60'd0, lk_hit, lk_type}, {60'd0, model(a)});
  endtask

  function automatic logic [63:0] mk_mask(input logic [51:0] size);
    return ({12'h0, ~(size - 52'd1)} & 64'h000F_FFFF_FFFF_F000) | 64'h800;
  endfunction

  task automatic sweep(input string tag);
    logic [51:0] anchors [6];
    logic [51:0] offs [10];
    anchors = '{52'h2000000, 52'h2100000, 52'hC00000000, 52'hC00100000, 52'h0, 52'h2180000};
    offs = '{-52'h1000, -52'h1, 52'h0, 52'h1, 52'hFFF, 52'h1000, 52'h7FFFF,
             52'hFFFFF, 52'h100000, 52'h1FFFFFF};
    foreach (anchors[i]) foreach (offs[j]) look(anchors[i] + offs[j], tag);
    for (int n = 0; n < 200; n++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17);
      look({rng[51:28] & 24'h00000C, 3'b000, rng[24:0]}, tag);
      look(rng[51:0], tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mbase[i] = '0; mmask[i] = '0; end
    mctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(12'h2FF, 64'h0, 1'b0, "R10 ctrl after reset");
    rd(12'h201, 64'h0, 1'b0, "R10 mask after reset");
    look(52'h0, "R10 lookup after reset");
    look(52'hFFFFFFFFFFFFF, "R10 lookup after reset");

    // R1 capability
    rd(12'h0FE, 64'd8, 1'b0, "R1 capability");
    wr(12'h0FE, '1);
    rd(12'h0FE, 64'd8, 1'b0, "R1 capability after write");

    // R2 field placement and reserved bits
    wr(12'h20E, '1);
    wr(12'h20F, '1);
    rd(12'h20E, 64'h000F_FFFF_FFFF_F007, 1'b0, "R2 base readback");
    rd(12'h20F, 64'h000F_FFFF_FFFF_F800, 1'b0, "R2 mask readback");
    wr(12'h20E, 64'h0);
    wr(12'h20F, 64'h0);
    rd(12'h20F, 64'h0, 1'b0, "R2 mask cleared");

    // R3 control register
    wr(12'h2FF, '1);
    rd(12'h2FF, 64'h807, 1'b0, "R3 ctrl readback");
    wr(12'h2FF, 64'h0);

    // R9 unimplemented indices
    rd(12'h210, 64'h0, 1'b1, "R9 past last pair");
    rd(12'h1FF, 64'h0, 1'b1, "R9 below pairs");
    rd(12'h2FE, 64'h0, 1'b1, "R9 near ctrl");
    rd(12'h200, 64'h0, 1'b0, "R9 implemented read");

    // overlapping configuration
    wr(12'h200, 64'h2000000 | 64'd6);   wr(12'h201, mk_mask(52'h2000000));
    wr(12'h202, 64'hC00000000 | 64'd1); wr(12'h203, mk_mask(52'h200000));
    wr(12'h204, 64'h2100000 | 64'd4);   wr(12'h205, mk_mask(52'h100000));
    wr(12'h206, 64'hC00100000);         wr(12'h207, mk_mask(52'h1000));
    wr(12'h208, 64'h2180000 | 64'd5);   wr(12'h209, mk_mask(52'h80000));
    wr(12'h20A, 64'd6);                 wr(12'h20B, 64'h0);
    wr(12'h2FF, 64'h800 | 64'd6);

    // R4 R5 R6 R8 match, invalid entry, fallback, overlap
    look(52'h2000000, "R4 base of WB range");
    look(52'h3FFFFFF, "R4 last byte of WB range");
    look(52'h4000000, "R6 just past WB range");
    look(52'h2100000, "R8 WT over WB");
    look(52'h2180000, "R8 mixed types to UC");
    look(52'hC00100000, "R8 UC wins");
    sweep("R4/R5/R6/R8 sweep");

    // R5 all-zero mask with valid clear, then valid set
    wr(12'h20B, 64'h800);
    look(52'h7000000, "R8 catch-all WB");
    look(52'hC00000000, "R8 WC+WB to UC");
    sweep("R8 catch-all sweep");
    wr(12'h20B, 64'h0);

    // R11 write coinciding with lookup
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 12'h2FF; reg_wdata = 64'h801;
    lk_valid = 1'b1; lk_addr = 52'h9000000;
    @(negedge clk);
    reg_wr = 1'b0; lk_valid = 1'b0;
    check("R11 lookup uses old ctrl", {60'd0, lk_hit, lk_type}, 64'h6);
    model_write(12'h2FF, 64'h801);
    repeat (3) @(negedge clk);
    check("R11 result held", {60'd0, lk_hit, lk_type}, 64'h6);
    look(52'h9000000, "R11 new ctrl seen");

    // R7 enable clear
    wr(12'h2FF, 64'h006);
    look(52'h2000000, "R7 disabled in range");
    sweep("R7 disabled sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule